// File: doc/BRIEF.md
# Split carry-select next-PC adder

This block produces the address of the next sequential instruction. It takes a 32-bit program counter and two decoded length flags. One flag says whether the instruction carries a register-specifier byte. The other says whether it carries a 4-byte constant. The sum is built from two independent pieces:

- The upper 29 bits of the PC feed an incrementer. It can start as soon as the PC is settled and does not wait for the flags.
- A 3-bit adder combines the low 3 bits with the instruction length, which arrives late from decode.
- The carry out of that small adder picks either the incremented upper field or the untouched one.

The selected upper field and the 3-bit sum are then joined to form the result. The combinational result is captured in an output register with a clock enable, so a fetch stage can place it straight onto its PC path. A parameter removes that register when the caller wants the raw combinational value.

Top module: `spc_next_pc`

## Requirements
- R1: While `rst_n` is low, `pc_next` is 0.
- R2: On a rising clock edge with `en` high, `pc_next` becomes `(pc_in + step) mod 2^32`, where step is the instruction length. The new value is visible after that edge.
- R3: The step is 1, plus 1 when `has_reg` is 1, plus 4 when `has_const` is 1. This gives the values 1, 2, 5 and 6.
- R4: When `pc_in[2:0] + step` is below 8, `pc_next[31:3]` equals `pc_in[31:3]`.
- R5: When `pc_in[2:0] + step` is 8 or more, `pc_next[31:3]` equals `pc_in[31:3] + 1`, taken modulo 2^29.
- R6: A PC near 0xFFFFFFFF wraps modulo 2^32. For example, 0xFFFFFFFF with step 6 gives 0x00000005.
- R7: On a rising edge with `en` low, `pc_next` keeps its value, whatever `pc_in` and the flags are.
- R8: `pc_next[2:0]` equals `(pc_in[2:0] + step) mod 8`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for the output register |
| pc_in | input | 32 | Current program counter |
| has_reg | input | 1 | Instruction carries a register-specifier byte |
| has_const | input | 1 | Instruction carries a 4-byte constant |
| pc_next | output | 32 | Address of the next sequential instruction |

## Verification
The bench sweeps every low-bit value from 0 to 7 against all four flag combinations. It does this at several upper-field bases, including one that makes the upper incrementer ripple across bit 31 and the all-ones base where the result wraps.

A design with an inverted select would add 8 to results that do not cross a boundary and drop 8 from those that do. A design with a missing or misplaced carry bit would fail only at the exact crossings. A step encoded in the wrong bits would show up at base 0, where the raw sum is exposed.

Cycles with `en` low and changed inputs expose a register that updates when it should hold.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int unsigned PC_W  = 32;
  localparam int unsigned LO_W  = 3;
  localparam int unsigned HI_W  = PC_W - LO_W;
  typedef logic [LO_W-1:0] lo_t;
  typedef logic [HI_W-1:0] hi_t;
  typedef logic [PC_W-1:0] pc_t;
endpackage

// File: rtl/spc_hi_inc.sv
// Early path: upper field plus one; independent of the length flags.
module spc_hi_inc #(
  parameter int unsigned HI_W = 29
) (
  input  logic [HI_W-1:0] hi_in,
  output logic [HI_W-1:0] hi_plus
);
  always_comb begin
    hi_plus = hi_in + HI_W'(1);
  end
endmodule

// File: rtl/spc_lo_add.sv
// Late path: low field plus instruction length, with carry out.
module spc_lo_add #(
  parameter int unsigned LO_W = 3
) (
  input  logic [LO_W-1:0] lo_in,
  input  logic            has_reg,
  input  logic            has_const,
  output logic [LO_W-1:0] lo_sum,
  output logic            carry
);
  logic [LO_W-1:0] step;
  logic [LO_W:0]   wide;

  always_comb begin
    // 1 + reg byte + 4 * constant, encoded directly in three bits
    step = LO_W'({has_const, has_reg, ~has_reg});
    wide = {1'b0, lo_in} + {1'b0, step};
    lo_sum = wide[LO_W-1:0];
    carry  = wide[LO_W];
  end
endmodule

// File: rtl/spc_hi_sel.sv
// Carry-driven 2:1 choice of upper field, then join with low sum.
module spc_hi_sel #(
  parameter int unsigned HI_W = 29,
  parameter int unsigned LO_W = 3
) (
  input  logic [HI_W-1:0]      hi_keep,
  input  logic [HI_W-1:0]      hi_plus,
  input  logic                 carry,
  input  logic [LO_W-1:0]      lo_sum,
  output logic [HI_W+LO_W-1:0] pc_sum
);
  logic [HI_W-1:0] hi_pick;

  always_comb begin
    hi_pick = carry ? hi_plus : hi_keep;
    pc_sum  = {hi_pick, lo_sum};
  end
endmodule

// File: rtl/spc_next_pc.sv
module spc_next_pc
  import spc_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [PC_W-1:0] pc_in,
  input  logic            has_reg,
  input  logic            has_const,
  output logic [PC_W-1:0] pc_next
);
  hi_t hi_plus;
  lo_t lo_sum;
  logic carry;
  pc_t pc_sum;

  spc_hi_inc #(.HI_W(HI_W)) u_hi (
    .hi_in   (pc_in[PC_W-1:LO_W]),
    .hi_plus (hi_plus)
  );

  spc_lo_add #(.LO_W(LO_W)) u_lo (
    .lo_in     (pc_in[LO_W-1:0]),
    .has_reg   (has_reg),
    .has_const (has_const),
    .lo_sum    (lo_sum),
    .carry     (carry)
  );

  spc_hi_sel #(.HI_W(HI_W), .LO_W(LO_W)) u_sel (
    .hi_keep (pc_in[PC_W-1:LO_W]),
    .hi_plus (hi_plus),
    .carry   (carry),
    .lo_sum  (lo_sum),
    .pc_sum  (pc_sum)
  );

  generate
    if (REG_OUT) begin : g_reg
      pc_t pc_q, pc_d;

      always_comb begin
        pc_d = pc_q;
        if (en) pc_d = pc_sum;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
      end

      assign pc_next = pc_q;

      // Independent full-width reference for the checks below
      pc_t chk_ref;
      assign chk_ref = pc_in + PC_W'(has_reg) + PC_W'({has_const, 2'b00}) + PC_W'(1);

      AST_FULL_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> pc_next == $past(chk_ref)); // R2
      AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ((pc_next - $past(pc_in)) >= PC_W'(1)) && ((pc_next - $past(pc_in)) <= PC_W'(6))); // R3
      AST_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !carry) |=> pc_next[PC_W-1:LO_W] == $past(pc_in[PC_W-1:LO_W])); // R4
      AST_HI_BUMPED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && carry) |=> pc_next[PC_W-1:LO_W] == $past(hi_plus)); // R5
      AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(pc_next)); // R7
      always_comb begin
        if (!rst_n) AST_RESET_ZERO: assert (pc_q == '0); // R1
      end
    end else begin : g_comb
      assign pc_next = pc_sum;
      wire unused_ok = &{1'b0, clk, rst_n, en};
    end
  endgenerate
endmodule

// File: tb/sim_spc_next_pc.sv
module sim_spc_next_pc;
  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] pc_in = '0;
  logic        has_reg = 1'b0;
  logic        has_const = 1'b0;
  logic [31:0] pc_next;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] last_exp = '0;
  item_t q[$];

  always #2 clk = ~clk;  // 250 MHz

  spc_next_pc u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .pc_in(pc_in),
    .has_reg(has_reg), .has_const(has_const), .pc_next(pc_next)
  );

  // Driver: applies stimulus and queues the expected result
  task automatic drive(input logic [31:0] pc, input logic r, input logic c,
                       input logic e, input string tag);
    item_t it;
    logic [31:0] step;
    @(negedge clk);
    pc_in = pc; has_reg = r; has_const = c; en = e;
    step = 32'd1 + (r ? 32'd1 : 32'd0) + (c ? 32'd4 : 32'd0);
    if (e) last_exp = pc + step;
    it.exp = last_exp;
    it.tag = tag;
    @(posedge clk);
    #1 q.push_back(it);
  endtask

  // Monitor: compares design output against queued expectation
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (pc_next !== it.exp) begin
        bad++;
        $display("FAIL %s: pc_next=%h expected=%h", it.tag, pc_next, it.exp);
      end
    end
  end

  function automatic string tag_for(input logic [31:0] base, input int lo,
                                    input logic r, input logic c);
    int s;
    s = lo + 1 + (r ? 1 : 0) + (c ? 4 : 0);
    if (base == 32'hFFFF_FFF8) return "R6";
    if (base == 32'h0000_0000) return "R8";
    if (base == 32'h0000_1000) return "R3";
    return (s >= 8) ? "R5" : "R4";
  endfunction

  initial begin
    logic [31:0] bases [4];
    bases[0] = 32'h0000_0000; bases[1] = 32'h0000_1000;
    bases[2] = 32'h7FFF_FFF8; bases[3] = 32'hFFFF_FFF8;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (pc_next !== 32'h0) begin
      bad++;
      $display("FAIL R1: pc_next=%h expected=%h", pc_next, 32'h0);
    end
    rst_n = 1'b1;

    // Boundary sweep: every low value, every flag pair, several bases
    for (int b = 0; b < 4; b++)
      for (int lo = 0; lo < 8; lo++)
        for (int f = 0; f < 4; f++)
          drive(bases[b] | 32'(lo), f[0], f[1], 1'b1, tag_for(bases[b], lo, f[0], f[1]));

    // R6: explicit wrap of all-ones PC
    drive(32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, "R6");
    drive(32'hFFFF_FFFA, 1'b0, 1'b1, 1'b1, "R6");

    // R7: enable low holds, with changed inputs
    drive(32'h1234_5677, 1'b1, 1'b0, 1'b1, "R2");
    drive(32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, "R7");
    drive(32'h0000_0007, 1'b0, 1'b1, 1'b0, "R7");

    // R2: random PCs
    for (int i = 0; i < 300; i++) begin
      logic [31:0] rp;
      rp = $urandom();
      drive(rp, 1'($urandom()), 1'($urandom()), 1'b1, "R2");
    end

    @(negedge clk); en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog: done=%0d expected=1", done);
      end
    join_any
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule